// File: doc/BRIEF.md
# Sleep-Depth Sequencer with Wake Qualification

This block moves a small microcontroller between running and three sleep depths: light sleep (idle), power-down and deep power-down. It drives the enables for the processor clock, the peripheral clock and the oscillator, plus a retention enable that keeps register and RAM state alive. It runs from an always-on clock. Software asks for a depth by writing a 2-bit code. From then on the block decides which interrupt sources may bring the chip back.

Each depth has its own set of wake sources:

- Light sleep ends on a peripheral interrupt, an enabled capture-pin interrupt or an enabled external pin.
- Power-down and deep power-down end only on an enabled external pin.

After the two deeper depths the oscillator is restarted. Every clock stays gated until the oscillator has reported stable for a programmable number of consecutive cycles. Deep power-down loses state, so its exit ends in a short reset pulse rather than a wake interrupt.

The three external pins are conditioned inside the block. Each pin is edge or level sensitive and has its own polarity. An edge-sensitive pin has a sticky flag that software clears by writing 1. A wake event present in the same cycle as a sleep request cancels that request.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset the block is in run: `cpu_clk_en`, `periph_clk_en`, `osc_en` and `retain_en` are 1. `mode_field`, `ext_flag`, `wake_irq` and `sys_rst_out` are 0.
- R2: Mode codes are 00 run, 01 idle, 10 power-down and 11 deep power-down. A non-zero write made while in run takes effect at the next clock edge. `mode_field` then reads the code while asleep and returns to 00 on wake. In every cycle `cpu_clk_en` is 1 exactly when `mode_field` is 00.
- R3: In idle, `cpu_clk_en` is 0 while `periph_clk_en` and `osc_en` stay 1. Any of these wakes the block: `periph_irq`, a capture line whose `cap_en` bit is set, or an active external pin whose wake enable is set. The block returns to run at the next edge, and `wake_irq` is 1 for exactly one cycle.
- R4: In power-down, both clock enables and `osc_en` are 0 and `retain_en` is 1. `periph_irq` and capture lines are ignored there.
- R5: In deep power-down, `retain_en` is also 0 and stays 0 until the oscillator has settled. Only external pins can wake from this depth.
- R6: A wake from power-down or deep power-down sets `osc_en` to 1 while both clocks stay off. The clocks stay off until `osc_stable` has been 1 for (`settle_sel`+1)*16 consecutive cycles. A low cycle restarts that count.
- R7: After settling from deep power-down, `sys_rst_out` is 1 for 4 cycles. During those cycles the clocks are on, `retain_en` is 1 and `wake_irq` stays 0. The block then runs. A power-down exit instead goes straight to run with a one-cycle `wake_irq`.
- R8: An external pin whose `ext_edge` bit is 1 sets its `ext_flag` bit on a rising edge when its `ext_pol` bit is 1, and on a falling edge when that bit is 0. The flag holds until a 1 is written on `ext_flag_clr`. A new edge in the same cycle as the clear wins.
- R9: An external pin whose `ext_edge` bit is 0 is active while the pin equals its `ext_pol` bit. Its `ext_flag` bit reads 0.
- R10: An external pin wakes the block only when its `ext_wake_en` bit is 1.
- R11: A sleep request is cancelled, and the block stays in run with `mode_field` at 00, when a wake source valid for the requested depth is active in the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Requested mode code |
| settle_sel | input | 8 | Oscillator settle length, (value+1)*16 cycles |
| osc_stable | input | 1 | Oscillator stable indication |
| periph_irq | input | 1 | OR of enabled peripheral interrupts |
| cap_irq | input | 10 | Capture-pin interrupt lines |
| cap_en | input | 10 | Capture interrupt enables |
| ext_pin | input | 3 | External interrupt pins |
| ext_edge | input | 3 | 1 selects edge mode per pin |
| ext_pol | input | 3 | Rising/active-high when 1 |
| ext_wake_en | input | 3 | External pin wake enables |
| ext_flag_clr | input | 3 | Write-1-to-clear for edge flags |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| retain_en | output | 1 | State retention enable |
| wake_irq | output | 1 | One-cycle wake interrupt |
| sys_rst_out | output | 1 | Reset pulse after deep wake |
| mode_field | output | 2 | Current mode code |
| ext_flag | output | 3 | Sticky edge flags |

## Verification
The assertions check the following in every cycle:

- The clock and oscillator enables stay consistent with each other and with `mode_field`.
- `wake_irq` never lasts longer than one cycle.
- The reset pulse never coincides with a wake interrupt or with lost retention.
- The clocks stay off while a settle is waiting on an unstable oscillator.
- Level-mode pins never show a flag.

Only the directed scenarios can show the rest:

- Which sources wake which depth.
- The exact settle length, including its restart on a low cycle.
- The four-cycle reset length.
- Sticky-flag clearing and set-over-clear priority.
- Cancellation of a request by a simultaneous wake.

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int N_EXT   = 3,
  parameter int N_CAP   = 10,
  parameter int SEL_W   = 8,
  parameter int RST_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [1:0]       mode_wdata,
  input  logic [SEL_W-1:0] settle_sel,
  input  logic             osc_stable,
  input  logic             periph_irq,
  input  logic [N_CAP-1:0] cap_irq,
  input  logic [N_CAP-1:0] cap_en,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic [N_EXT-1:0] ext_edge,
  input  logic [N_EXT-1:0] ext_pol,
  input  logic [N_EXT-1:0] ext_wake_en,
  input  logic [N_EXT-1:0] ext_flag_clr,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             osc_en,
  output logic             retain_en,
  output logic             wake_irq,
  output logic             sys_rst_out,
  output logic [1:0]       mode_field,
  output logic [N_EXT-1:0] ext_flag
);
  localparam int CNT_W = SEL_W + 5;
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYC - 1);

  typedef enum logic [2:0] {S_RUN, S_IDLE, S_PD, S_DPD, S_SETTLE, S_RSTP} st_t;

  st_t              st_q, st_d;
  logic [1:0]       mode_q;
  logic             deep_q, wirq_q;
  logic [CNT_W-1:0] cnt_q;
  logic [N_EXT-1:0] pin_q, flag_q;

  wire [N_EXT-1:0] lvl_on   = ~(ext_pin ^ ext_pol);
  wire [N_EXT-1:0] rise     = ext_pin & ~pin_q;
  wire [N_EXT-1:0] fall     = ~ext_pin & pin_q;
  wire [N_EXT-1:0] edge_hit = ext_edge & ((ext_pol & rise) | (~ext_pol & fall));
  wire [N_EXT-1:0] ext_act  = (ext_edge & flag_q) | (~ext_edge & lvl_on);

  wire ext_wake   = |(ext_act & ext_wake_en);
  wire light_wake = ext_wake | periph_irq | (|(cap_irq & cap_en));

  wire [CNT_W-1:0] settle_len  = (CNT_W'(settle_sel) + CNT_W'(1)) << 4;
  wire [CNT_W-1:0] settle_last = settle_len - CNT_W'(1);
  wire settle_done = osc_stable && (cnt_q == settle_last);
  wire rst_done    = (cnt_q == RST_LAST);

  wire entry_req = mode_wr && (mode_wdata != 2'b00);
  wire cancel    = (mode_wdata == 2'b01) ? light_wake : ext_wake;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_RUN:
        if (entry_req && !cancel)
          st_d = (mode_wdata == 2'b01) ? S_IDLE :
                 (mode_wdata == 2'b10) ? S_PD : S_DPD;
      S_IDLE:   if (light_wake) st_d = S_RUN;
      S_PD,
      S_DPD:    if (ext_wake) st_d = S_SETTLE;
      S_SETTLE: if (settle_done) st_d = deep_q ? S_RSTP : S_RUN;
      S_RSTP:   if (rst_done) st_d = S_RUN;
      default:  st_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_RUN;
      mode_q <= 2'b00;
      deep_q <= 1'b0;
      wirq_q <= 1'b0;
      cnt_q  <= '0;
      pin_q  <= '0;
      flag_q <= '0;
    end else begin
      st_q   <= st_d;
      pin_q  <= ext_pin;
      flag_q <= ext_edge & ((flag_q & ~ext_flag_clr) | edge_hit);
      wirq_q <= (st_d == S_RUN) && (st_q == S_IDLE || st_q == S_SETTLE);

      if (st_q == S_RUN && st_d != S_RUN)
        mode_q <= mode_wdata;
      else if ((st_q == S_IDLE || st_q == S_SETTLE) && st_d != st_q)
        mode_q <= 2'b00;

      if (st_q == S_DPD)      deep_q <= 1'b1;
      else if (st_q == S_RUN) deep_q <= 1'b0;

      if (st_q == S_SETTLE)
        cnt_q <= (!osc_stable || settle_done) ? '0 : cnt_q + CNT_W'(1);
      else if (st_q == S_RSTP)
        cnt_q <= rst_done ? '0 : cnt_q + CNT_W'(1);
      else
        cnt_q <= '0;
    end
  end

  assign cpu_clk_en    = (st_q == S_RUN) || (st_q == S_RSTP);
  assign periph_clk_en = cpu_clk_en || (st_q == S_IDLE);
  assign osc_en        = !(st_q == S_PD || st_q == S_DPD);
  assign retain_en     = !(st_q == S_DPD || (st_q == S_SETTLE && deep_q));
  assign sys_rst_out   = (st_q == S_RSTP);
  assign wake_irq      = wirq_q;
  assign mode_field    = mode_q;
  assign ext_flag      = flag_q;

  // R4
  clocks_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!cpu_clk_en && !periph_clk_en));

  // R2
  mode_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_field == 2'b00) == cpu_clk_en);

  // R3
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);

  // R5
  retain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !retain_en |-> !cpu_clk_en);

  // R6
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && !periph_clk_en && !osc_stable) |=> !cpu_clk_en);

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_out |-> (!wake_irq && retain_en && cpu_clk_en));

  // R9
  for (genvar i = 0; i < N_EXT; i++) begin : g_lvl
    level_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!ext_edge[i]) |-> !ext_flag[i]);
  end
endmodule

// File: tb/sleep_wake_ctrl_tb.sv
module sleep_wake_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic [7:0] settle_sel = 8'd0;
  logic osc_stable = 1'b1, periph_irq = 1'b0;
  logic [9:0] cap_irq = '0, cap_en = '0;
  logic [2:0] ext_pin = '0, ext_edge = '0, ext_pol = 3'b111, ext_wake_en = '0, ext_flag_clr = '0;
  logic cpu_clk_en, periph_clk_en, osc_en, retain_en, wake_irq, sys_rst_out;
  logic [1:0] mode_field;
  logic [2:0] ext_flag;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_wake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .settle_sel(settle_sel), .osc_stable(osc_stable), .periph_irq(periph_irq),
    .cap_irq(cap_irq), .cap_en(cap_en), .ext_pin(ext_pin), .ext_edge(ext_edge),
    .ext_pol(ext_pol), .ext_wake_en(ext_wake_en), .ext_flag_clr(ext_flag_clr),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .retain_en(retain_en), .wake_irq(wake_irq), .sys_rst_out(sys_rst_out),
    .mode_field(mode_field), .ext_flag(ext_flag));

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(logic [1:0] code);
    mode_wdata = code; mode_wr = 1'b1;
    tick();
    mode_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "cpu_clk_en", cpu_clk_en, 1);
    check("R1", "periph_clk_en", periph_clk_en, 1);
    check("R1", "osc_en", osc_en, 1);
    check("R1", "retain_en", retain_en, 1);
    check("R1", "mode_field", mode_field, 0);
    check("R1", "ext_flag", ext_flag, 0);
    check("R1", "wake_irq", wake_irq, 0);
    check("R1", "sys_rst_out", sys_rst_out, 0);
  endtask

  task automatic t_idle();
    wr_mode(2'b01);
    check("R3", "idle cpu", cpu_clk_en, 0);
    check("R3", "idle periph", periph_clk_en, 1);
    check("R3", "idle osc", osc_en, 1);
    check("R2", "idle mode", mode_field, 1);
    periph_irq = 1'b1; tick();
    check("R3", "periph wake cpu", cpu_clk_en, 1);
    check("R3", "wake_irq", wake_irq, 1);
    check("R2", "mode cleared", mode_field, 0);
    periph_irq = 1'b0; tick();
    check("R3", "wake_irq one cycle", wake_irq, 0);
    cap_en = 10'h008;
    wr_mode(2'b01);
    cap_irq = 10'h020; tick();
    check("R3", "disabled capture ignored", cpu_clk_en, 0);
    cap_irq = 10'h028; tick();
    check("R3", "capture wake", cpu_clk_en, 1);
    cap_irq = '0; tick();
    periph_irq = 1'b1;
    wr_mode(2'b01);
    check("R11", "idle cancel cpu", cpu_clk_en, 1);
    check("R11", "idle cancel mode", mode_field, 0);
    periph_irq = 1'b0; tick();
  endtask

  task automatic t_pd();
    settle_sel = 8'd0;
    wr_mode(2'b10);
    check("R4", "pd cpu", cpu_clk_en, 0);
    check("R4", "pd periph", periph_clk_en, 0);
    check("R4", "pd osc", osc_en, 0);
    check("R4", "pd retain", retain_en, 1);
    check("R2", "pd mode", mode_field, 2);
    osc_stable = 1'b0;
    periph_irq = 1'b1; cap_irq = 10'h008; ext_pin[0] = 1'b1;
    tick(3);
    check("R4", "periph/capture ignored", osc_en, 0);
    check("R10", "disabled pin ignored", osc_en, 0);
    periph_irq = 1'b0; cap_irq = '0;
    ext_wake_en = 3'b001; tick();
    check("R6", "settle osc", osc_en, 1);
    check("R6", "settle cpu", cpu_clk_en, 0);
    tick(2);
    osc_stable = 1'b1; tick(8);
    osc_stable = 1'b0; tick();
    osc_stable = 1'b1; tick(15);
    check("R6", "before count", cpu_clk_en, 0);
    tick();
    check("R6", "after count", cpu_clk_en, 1);
    check("R7", "pd exit wake_irq", wake_irq, 1);
    check("R2", "pd mode cleared", mode_field, 0);
    ext_pin = '0; ext_wake_en = '0; tick();
  endtask

  task automatic t_dpd();
    settle_sel = 8'd1;
    ext_edge = 3'b010; ext_pol = 3'b101; ext_pin[1] = 1'b1; tick();
    check("R8", "no flag on wrong edge", ext_flag, 0);
    ext_wake_en = 3'b010;
    wr_mode(2'b11);
    check("R5", "dpd retain", retain_en, 0);
    check("R5", "dpd osc", osc_en, 0);
    check("R2", "dpd mode", mode_field, 3);
    osc_stable = 1'b0; periph_irq = 1'b1; tick();
    check("R5", "periph ignored", osc_en, 0);
    periph_irq = 1'b0;
    ext_pin[1] = 1'b0; tick();
    check("R8", "falling edge flag", ext_flag, 2);
    tick();
    check("R6", "dpd settle osc", osc_en, 1);
    check("R5", "settle retain", retain_en, 0);
    osc_stable = 1'b1; tick(31);
    check("R6", "dpd before count", cpu_clk_en, 0);
    tick();
    check("R7", "rst pulse", sys_rst_out, 1);
    check("R7", "rst cpu", cpu_clk_en, 1);
    check("R7", "rst retain", retain_en, 1);
    check("R7", "rst no wake_irq", wake_irq, 0);
    tick(3);
    check("R7", "rst 4th cycle", sys_rst_out, 1);
    tick();
    check("R7", "rst ended", sys_rst_out, 0);
    check("R7", "run after rst", cpu_clk_en, 1);
    ext_flag_clr = 3'b010; tick();
    ext_flag_clr = '0;
    check("R8", "flag cleared", ext_flag, 0);
    ext_wake_en = '0; tick();
  endtask

  task automatic t_edge();
    ext_edge = 3'b100; ext_pol = 3'b101;
    ext_pin[2] = 1'b1; tick();
    check("R8", "rising flag", ext_flag, 4);
    ext_pin[2] = 1'b0; tick();
    check("R8", "flag sticky", ext_flag, 4);
    ext_flag_clr = 3'b100; ext_pin[2] = 1'b1; tick();
    check("R8", "set wins over clear", ext_flag, 4);
    tick();
    check("R8", "clear", ext_flag, 0);
    ext_flag_clr = '0; ext_pin = '0; ext_edge = '0; tick();
  endtask

  task automatic t_level();
    ext_pol = 3'b110; ext_pin[0] = 1'b1; ext_wake_en = 3'b001; tick();
    ext_pin[0] = 1'b0;
    wr_mode(2'b10);
    check("R11", "pd cancel osc", osc_en, 1);
    check("R11", "pd cancel mode", mode_field, 0);
    check("R9", "level no flag", ext_flag, 0);
    ext_pin[0] = 1'b1; tick();
    wr_mode(2'b01);
    check("R9", "inactive level", cpu_clk_en, 0);
    ext_pin[0] = 1'b0; tick();
    check("R9", "active-low wake", cpu_clk_en, 1);
    check("R3", "level wake_irq", wake_irq, 1);
    ext_wake_en = '0; ext_pol = 3'b111; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_idle();
    t_pd();
    t_dpd();
    t_edge();
    t_level();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule